// File: doc/BRIEF.md
# Byte-Addressable Load/Store Unit

This block is the data-memory access stage of a 32-bit load/store processor core. Each request carries an operation, a 32-bit byte address and 32-bit store data. The unit performs a word load, byte load, word store or byte store against a small internal byte-addressed array. It returns registered load data together with an alignment-fault pulse.

The array is split into four byte-wide banks. A whole word therefore moves in one access, and a byte store touches a single bank. The bytes within a word are little-endian. Word accesses must be aligned to four bytes. A word access that is not aligned raises the fault and has no other effect. Byte loads are sign-extended. Only the low address bits that index the array are decoded, so the higher bits alias.

Top module: `lsu_core`

## Requirements
- R1: After reset, rdata_o is 0 and fault_o is 0.
- R2: An aligned word store followed by a word load to the same address returns the full stored 32-bit value from one access.
- R3: Byte order is little-endian: the byte at address 4k+i occupies bits 8i+7:8i of the word at 4k.
- R4: A byte load returns the addressed byte in bits 7:0 with bit 7 copied into bits 31:8.
- R5: A byte store writes only wdata_i[7:0] to the addressed byte; the other three bytes of that word are unchanged.
- R6: A word load or store whose addr_i[1:0] is not 00 raises fault_o in exactly the cycle after the request, for that one cycle.
- R7: A misaligned word store leaves memory unchanged.
- R8: A misaligned word load leaves rdata_o unchanged.
- R9: Byte loads and stores are accepted at any address and never raise fault_o.
- R10: Load data appears on rdata_o in the cycle after the request. rdata_o holds its value through stores, faults and idle cycles.
- R11: Only the low log2(DEPTH) address bits select a byte, so addresses that differ only above them reach the same location.
- R12: op_i encodes 2'b00 word load, 2'b01 byte load, 2'b10 word store and 2'b11 byte store. Nothing happens while req_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation code |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store data |
| rdata_o | output | 32 | Load data, valid the cycle after a load |
| fault_o | output | 1 | Misaligned word access pulse |

## Verification
The bench targets the lane boundaries: bytes 0 and 3 of a word, and byte values with bit 7 set and with bit 7 clear. A design with swapped endianness returns the wrong byte, and one that zero-extends returns a positive value for 0x80 to 0xFF. It stores a byte between known neighbours and reads the whole word back, which exposes a write-enable decode that clobbers adjacent bytes. Misaligned word stores and loads are followed by aligned reads, so a design that writes anyway or updates rdata_o on a fault is caught. Random traffic with random upper address bits covers aliasing and the ordering of loads after stores.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    OP_LDW = 2'b00,
    OP_LDB = 2'b01,
    OP_STW = 2'b10,
    OP_STB = 2'b11
  } lsu_op_e;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LANES   = 4;
  localparam int unsigned WORD_W  = BYTE_W * LANES;
  localparam int unsigned LANE_W  = $clog2(LANES);
endpackage

// File: rtl/lsu_req_decode.sv
module lsu_req_decode
  import lsu_pkg::*;
#(
  parameter int unsigned ROW_W = 6
) (
  input  logic                 req_i,
  input  lsu_op_e              op_i,
  input  logic [31:0]          addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic                 rd_en_o,
  output logic [LANES-1:0]     be_o,
  output logic [WORD_W-1:0]    bank_wdata_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [LANE_W-1:0]    lane_o,
  output logic                 is_byte_o,
  output logic                 misalign_o
);
  logic is_word;

  assign lane_o     = addr_i[LANE_W-1:0];
  assign row_o      = addr_i[ROW_W+LANE_W-1:LANE_W];
  assign is_byte_o  = (op_i == OP_LDB) || (op_i == OP_STB);
  assign is_word    = !is_byte_o;
  assign misalign_o = req_i && is_word && (lane_o != '0);

  always_comb begin
    rd_en_o      = 1'b0;
    be_o         = '0;
    bank_wdata_o = wdata_i;
    if (req_i && !misalign_o) begin
      unique case (op_i)
        OP_LDW, OP_LDB: rd_en_o = 1'b1;
        OP_STW:         be_o    = '1;
        OP_STB: begin
          be_o         = LANES'(1) << lane_o;
          bank_wdata_o = {LANES{wdata_i[BYTE_W-1:0]}};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lsu_byte_bank.sv
module lsu_byte_bank
  import lsu_pkg::*;
#(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              rd_en_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[row_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mem_q[row_i];
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              is_byte_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] sel;

  assign sel     = word_i[lane_i*BYTE_W +: BYTE_W];
  assign rdata_o = is_byte_i ? {{(WORD_W-BYTE_W){sel[BYTE_W-1]}}, sel} : word_i;
endmodule

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter int unsigned DEPTH = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [1:0]  op_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        fault_o
);
  localparam int unsigned ROWS  = DEPTH / LANES;
  localparam int unsigned ROW_W = $clog2(ROWS);

  lsu_op_e             op;
  logic                rd_en, is_byte, misalign;
  logic [LANES-1:0]    be;
  logic [WORD_W-1:0]   bank_wdata, bank_q;
  logic [ROW_W-1:0]    row;
  logic [LANE_W-1:0]   lane, lane_q;
  logic                is_byte_q, fault_q;

  assign op = lsu_op_e'(op_i);

  lsu_req_decode #(.ROW_W(ROW_W)) u_dec (
    .req_i       (req_i),
    .op_i        (op),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rd_en_o     (rd_en),
    .be_o        (be),
    .bank_wdata_o(bank_wdata),
    .row_o       (row),
    .lane_o      (lane),
    .is_byte_o   (is_byte),
    .misalign_o  (misalign)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    lsu_byte_bank #(.ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (be[g]),
      .rd_en_i(rd_en),
      .row_i  (row),
      .wdata_i(bank_wdata[g*BYTE_W +: BYTE_W]),
      .rdata_o(bank_q[g*BYTE_W +: BYTE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q    <= '0;
      is_byte_q <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      fault_q <= misalign;
      if (rd_en) begin
        lane_q    <= lane;
        is_byte_q <= is_byte;
      end
    end
  end

  lsu_load_fmt u_fmt (
    .word_i   (bank_q),
    .lane_i   (lane_q),
    .is_byte_i(is_byte_q),
    .rdata_o  (rdata_o)
  );

  assign fault_o = fault_q;

  p_fault_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(req_i && !op_i[0] && addr_i[1:0] != 2'b00));
  p_byte_no_fault_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && op_i[0]) |-> !fault_o);
  p_no_write_on_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign |-> (be == '0) && !rd_en);
  p_be_shape_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(be) || (be == '1));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en) |-> $stable(rdata_o));
  p_sign_ext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en && is_byte) |-> rdata_o[31:8] == {24{rdata_o[7]}});
endmodule

// File: tb/lsu_core_test.sv
module lsu_core_test;
  localparam int DEPTH = 256;
  localparam logic [1:0] LW = 2'b00, LB = 2'b01, SW = 2'b10, SB = 2'b11;

  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic        fault;

  int errors = 0, checks = 0;
  logic [7:0]  mdl [DEPTH];
  logic [31:0] exp_rd = '0;
  bit done = 1'b0;

  lsu_core #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .fault_o(fault)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_load(input logic [1:0] o, input logic [31:0] a);
    int i = int'(a % DEPTH);
    if (o == LB) return {{24{mdl[i][7]}}, mdl[i]};
    return {mdl[i+3], mdl[i+2], mdl[i+1], mdl[i]};
  endfunction

  task automatic run(input logic [1:0] o, input logic [31:0] a, input logic [31:0] d, input string tag);
    bit mis = !o[0] && (a[1:0] != 2'b00);
    int i = int'(a % DEPTH);
    req = 1'b1; op = o; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    if (!mis) begin
      case (o)
        SW: for (int k = 0; k < 4; k++) mdl[i+k] = d[8*k +: 8];
        SB: mdl[i] = d[7:0];
        default: exp_rd = mdl_load(o, a);
      endcase
    end
    check(fault == mis, {tag, " fault"}, {31'd0, fault}, {31'd0, mis});
    check(rdata == exp_rd, {tag, " rdata"}, rdata, exp_rd);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    check(rdata == 32'd0 && fault == 1'b0, "R1 reset", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdata == 32'd0 && fault == 1'b0, "R1 after release", rdata, 32'd0);

    for (int r = 0; r < DEPTH; r += 4) run(SW, r, $urandom, "R2 init");

    run(SW, 32'h40, 32'h8899AABB, "R2 store");
    run(LW, 32'h40, 32'h0, "R2 load");
    run(LB, 32'h40, 32'h0, "R3 lane0");
    run(LB, 32'h41, 32'h0, "R3 lane1");
    run(LB, 32'h43, 32'h0, "R3 lane3");
    run(SW, 32'h44, 32'h12345678, "R4 store");
    run(LB, 32'h45, 32'h0, "R4 positive byte");
    run(LB, 32'h47, 32'h0, "R4 positive top");
    run(SB, 32'h46, 32'hDEADBE7F, "R5 byte store");
    run(LW, 32'h44, 32'h0, "R5 neighbours kept");
    run(SB, 32'h44, 32'h000000F0, "R5 byte store lane0");
    run(LB, 32'h44, 32'h0, "R4 negative byte");
    run(SW, 32'h49, 32'hCAFEF00D, "R6 misaligned store");
    run(LW, 32'h48, 32'h0, "R7 memory unchanged");
    run(LW, 32'h4A, 32'h0, "R8 misaligned load");
    run(LW, 32'h4B, 32'h0, "R6 misaligned load odd");
    run(LB, 32'h4B, 32'h0, "R9 byte load odd");
    run(SB, 32'h4D, 32'h00000081, "R9 byte store odd");
    run(LW, 32'h4C, 32'h0, "R9 readback");

    // idle request with store opcode: nothing may change
    op = SW; addr = 32'h40; wdata = 32'hFFFFFFFF;
    @(posedge clk); @(negedge clk);
    check(rdata == exp_rd && !fault, "R10 idle hold", rdata, exp_rd);
    run(LW, 32'h40, 32'h0, "R12 idle no write");
    run(SB, 32'h51, 32'h5A, "R10 store keeps rdata");

    run(SW, 32'h40 + DEPTH * 3, 32'h01020304, "R11 alias store");
    run(LW, 32'h40, 32'h0, "R11 alias load");
    run(LB, 32'h43 + DEPTH * 77, 32'h0, "R11 alias byte");

    for (int n = 0; n < 3000; n++) begin
      logic [1:0]  o = 2'($urandom);
      logic [31:0] a = $urandom;
      if (!o[0] && ($urandom % 4 != 0)) a[1:0] = 2'b00;
      run(o, a, $urandom, "R12 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule